// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the address sequence for a four-beat memory burst. A load command registers an external starting address. Each later advance command steps to the next beat's address, which the block computes itself; the address input is not used for these steps. A static order-select input chooses how the two lowest address bits move. In sequential order they count up modulo 4 from the starting value. In interleaved order each beat's low bits equal the starting low bits XOR the beat index. The bits above bit 1 keep their loaded value for the whole burst. After the fourth beat the sequence returns to where it started.

The order-select input is a board-level strap and must be held at a firm level. When the clock enable is low the block freezes completely.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset the output address is all zeros and the beat counter is 0.
- R2: A load command (`load_i`=1 with `clk_en_i`=1) makes the output equal `start_addr_i` at the next clock edge and sets the beat index to 0.
- R3: With `order_sel_i`=0 (sequential), each advance sets the low two bits to the previous low bits plus 1, modulo 4. Example: start 01 gives 01, 10, 11, 00.
- R4: With `order_sel_i`=1 (interleaved), each advance sets the low two bits to the start low bits XOR the new beat index. Example: start 10 gives 10, 11, 00, 01.
- R5: Address bits above bit 1 keep their loaded value for every advance.
- R6: The fourth advance after a load brings the output back to the loaded address and the beat index back to 0.
- R7: While `clk_en_i`=0, load and advance have no effect and the output holds its value.
- R8: When `load_i` and `adv_i` are both 1 in the same enabled cycle, the load wins.
- R9: When neither load nor advance is asserted, the output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Clock enable, active high |
| load_i | input | 1 | Register the starting address |
| adv_i | input | 1 | Step to the next beat |
| order_sel_i | input | 1 | Strap: 0 selects sequential order, 1 selects interleaved order |
| start_addr_i | input | ADDR_W | Starting address of the burst |
| addr_o | output | ADDR_W | Current burst address |

## Verification
The bench uses an 8-bit address, the default width. This keeps the upper bits wide enough that any disturbance of them is visible. The bench runs every one of the four starting low-bit values in both orders. It then runs long advance runs that cross the wrap point several times, and it mixes in stalled cycles and cycles where load and advance are both asserted. Since the order input is a strap, the bench changes it only between bursts, with a fresh load each time.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;
   localparam int unsigned BEAT_W = 2;
   localparam int unsigned BEATS  = 1 << BEAT_W;

   typedef enum logic [1:0] {
      CMD_HOLD = 2'd0,
      CMD_STEP = 2'd1,
      CMD_LOAD = 2'd2
   } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec
   import burst_addr_pkg::*;
(
   input  logic       clk_en_i,
   input  logic       load_i,
   input  logic       adv_i,
   output burst_cmd_e cmd_o
);
   always_comb begin
      if (!clk_en_i)   cmd_o = CMD_HOLD;
      else if (load_i) cmd_o = CMD_LOAD;
      else if (adv_i)  cmd_o = CMD_STEP;
      else             cmd_o = CMD_HOLD;
   end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
   import burst_addr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  burst_cmd_e        cmd_i,
   output logic [BEAT_W-1:0] beat_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                beat_o <= '0;
      else if (cmd_i == CMD_LOAD) beat_o <= '0;
      else if (cmd_i == CMD_STEP) beat_o <= beat_o + 1'b1;
   end

   // R6
   beat_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_STEP && beat_o == BEAT_W'(BEATS-1)) |=> beat_o == '0);
   // R2
   beat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_i == CMD_LOAD) |=> beat_o == '0);
endmodule

// File: rtl/burst_low_gen.sv
module burst_low_gen
   import burst_addr_pkg::*;
#(
   parameter bit HAS_INTERLEAVE = 1'b1
)(
   input  logic              order_sel_i,
   input  logic [BEAT_W-1:0] base_i,
   input  logic [BEAT_W-1:0] cur_i,
   input  logic [BEAT_W-1:0] next_beat_i,
   output logic [BEAT_W-1:0] low_o
);
   generate
      if (HAS_INTERLEAVE) begin : g_both
         always_comb low_o = order_sel_i ? (base_i ^ next_beat_i) : (cur_i + 1'b1);
      end else begin : g_seq
         logic unused_sel;
         always_comb unused_sel = order_sel_i ^ (|base_i) ^ (|next_beat_i);
         always_comb low_o = cur_i + 1'b1;
      end
   endgenerate
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import burst_addr_pkg::*;
#(
   parameter int unsigned ADDR_W         = 8,
   parameter bit          HAS_INTERLEAVE = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_en_i,
   input  logic              load_i,
   input  logic              adv_i,
   input  logic              order_sel_i,
   input  logic [ADDR_W-1:0] start_addr_i,
   output logic [ADDR_W-1:0] addr_o
);
   localparam int unsigned HI_W = ADDR_W - BEAT_W;

   initial begin
      if (ADDR_W <= BEAT_W) $error("ADDR_W must exceed the beat field width");
   end

   burst_cmd_e        cmd;
   logic [BEAT_W-1:0] beat;
   logic [BEAT_W-1:0] next_beat;
   logic [BEAT_W-1:0] base_low;
   logic [BEAT_W-1:0] step_low;
   logic [HI_W-1:0]   hi_q;
   logic [BEAT_W-1:0] low_q;

   burst_cmd_dec u_dec (
      .clk_en_i (clk_en_i),
      .load_i   (load_i),
      .adv_i    (adv_i),
      .cmd_o    (cmd)
   );

   burst_beat_ctr u_beat (
      .clk   (clk),
      .rst_n (rst_n),
      .cmd_i (cmd),
      .beat_o(beat)
   );

   always_comb next_beat = beat + 1'b1;

   burst_low_gen #(.HAS_INTERLEAVE(HAS_INTERLEAVE)) u_low (
      .order_sel_i (order_sel_i),
      .base_i      (base_low),
      .cur_i       (low_q),
      .next_beat_i (next_beat),
      .low_o       (step_low)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q     <= '0;
         low_q    <= '0;
         base_low <= '0;
      end else if (cmd == CMD_LOAD) begin
         hi_q     <= start_addr_i[ADDR_W-1:BEAT_W];
         low_q    <= start_addr_i[BEAT_W-1:0];
         base_low <= start_addr_i[BEAT_W-1:0];
      end else if (cmd == CMD_STEP) begin
         low_q    <= step_low;
      end
   end

   assign addr_o = {hi_q, low_q};

   // R5
   upper_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i || !clk_en_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));
   // R7
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_en_i |=> $stable(addr_o));
   // R2
   load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_i && load_i) |=> addr_o == $past(start_addr_i));
   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && !adv_i) |=> $stable(addr_o));
   // R3
   seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_en_i && !load_i && adv_i && !order_sel_i) |=>
         addr_o[BEAT_W-1:0] == BEAT_W'($past(addr_o[BEAT_W-1:0]) + 1'b1));
endmodule

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
   localparam int AW = 8;
   logic clk = 0, rst_n = 0, en = 0, ld = 0, adv = 0, sel = 0;
   logic [AW-1:0] sa = '0;
   logic [AW-1:0] addr;
   int nchk = 0, nfail = 0;
   int m_base, m_beat, m_addr;
   bit done = 0;

   always #2.5 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW)) u_burst_addr_seq (
      .clk(clk), .rst_n(rst_n), .clk_en_i(en), .load_i(ld), .adv_i(adv),
      .order_sel_i(sel), .start_addr_i(sa), .addr_o(addr));

   task automatic chk(input string req);
      nchk++;
      if (addr !== AW'(m_addr)) begin
         nfail++;
         $display("FAIL %s: got %02h expected %02h", req, addr, AW'(m_addr));
      end
   endtask

   // reference model update, applied at each edge from current inputs
   task automatic model_step();
      if (en) begin
         if (ld) begin
            m_addr = int'(sa); m_base = int'(sa) & 3; m_beat = 0;
         end else if (adv) begin
            m_beat = (m_beat + 1) % 4;
            if (sel) m_addr = (m_addr & ~3) | (m_base ^ m_beat);
            else     m_addr = (m_addr & ~3) | (((m_addr & 3) + 1) % 4);
         end
      end
   endtask

   task automatic cyc(input bit e, input bit l, input bit a, input logic [AW-1:0] s,
                      input string req);
      en = e; ld = l; adv = a; sa = s;
      @(posedge clk);
      model_step();
      #1;
      chk(req);
   endtask

   initial begin
      m_addr = 0; m_base = 0; m_beat = 0;
      repeat (2) @(posedge clk);
      #1; chk("R1");
      rst_n = 1;
      // R3 and R4 across all four start values, R5 upper bits, R6 wrap
      for (int o = 0; o < 2; o++) begin
         sel = o[0];
         for (int s = 0; s < 4; s++) begin
            cyc(1, 1, 0, AW'(8'hA4 | s), "R2");
            for (int k = 0; k < 4; k++) cyc(1, 0, 1, 8'h00, o ? "R4" : "R3");
            chk("R6");
         end
      end
      // specific sequence 10 -> 11,00,01 interleaved
      sel = 1; cyc(1, 1, 0, 8'h3E, "R2");
      cyc(1, 0, 1, 8'hFF, "R4"); cyc(1, 0, 1, 8'h00, "R4");
      // stall: load/advance ignored
      cyc(0, 1, 0, 8'h55, "R7"); cyc(0, 0, 1, 8'h55, "R7");
      cyc(1, 0, 1, 8'h00, "R4");
      cyc(1, 0, 0, 8'h77, "R9"); cyc(1, 0, 0, 8'h77, "R9");
      // load priority
      cyc(1, 1, 1, 8'hC9, "R8"); cyc(1, 1, 1, 8'h12, "R8");
      // long runs crossing wrap, sequential then interleaved
      sel = 0; cyc(1, 1, 0, 8'h6B, "R2");
      for (int k = 0; k < 11; k++) cyc(1, 0, 1, 8'h00, "R3");
      for (int k = 0; k < 6; k++) cyc(k % 2, k % 3 == 0, 1, 8'h91, "R7");
      sel = 1; cyc(1, 1, 0, 8'hF1, "R2");
      for (int k = 0; k < 13; k++) cyc(k % 4 != 2, 0, 1, 8'h00, "R5");
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            nchk++; nfail++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule